// File: doc/BRIEF.md
# Pixel Column Hit Capture and Readout

This block is the digital half of one column of self-triggered pixel cells together with the logic that reads the column out. A free-running 12-bit counter is converted to Gray code and shared with every cell. Each cell watches its comparator output, which is asynchronous to the clock. The cell records the bus value when the pulse starts and again when it ends, so the time over threshold, a proxy for collected charge, can be recovered later.

A column controller drains finished hits one at a time. The lowest-numbered ready cell is always served first. Each output word carries the cell address, both timestamps converted back to binary, and their modulo difference. The same controller gives a host read and write access to each cell's 12-bit configuration word, whose low five bits drive the cell's threshold trim.

The readout controller has two states. `RD_IDLE` waits for a ready cell. It moves to `RD_SEND` when a cell is ready and no configuration access is requested in that cycle; on that move it loads the output word and acknowledges the cell. `RD_SEND` presents the word and returns to `RD_IDLE` when `hit_ready` is high. Each cell has three states. `CELL_ARMED` moves to `CELL_OPEN` on a synchronized rising edge and captures the leading timestamp. `CELL_OPEN` moves to `CELL_FULL` on a falling edge and captures the trailing timestamp. `CELL_FULL` returns to `CELL_ARMED` on acknowledge.

Top module: `pxcol_top`

## Requirements
- R1: The shared timestamp bus is Gray-coded and changes by at most one bit per clock. Output timestamps are plain binary.
- R2: Each comparator input passes through a two-flop synchronizer. The leading timestamp is the bus value on the cycle the synchronized rising edge is detected, so it sits a fixed number of cycles after the comparator rises.
- R3: The trailing timestamp is taken the same way on the falling edge. `hit_tot` equals (trail - lead) mod 4096, which is the pulse length in clocks for any pulse shorter than 4096 clocks, including pulses that span a counter wrap.
- R4: A configuration write (`cfg_req`=1, `cfg_we`=1) stores `cfg_wdata` in the addressed cell. A read (`cfg_req`=1, `cfg_we`=0) returns that cell's word on `cfg_rdata` with `cfg_rvalid` high in the next cycle only.
- R5: The trim output of cell i (`trim_o[5i+4:5i]`) equals bits [4:0] of that cell's configuration word.
- R6: When several cells are ready, they are read out in ascending address order.
- R7: A cell reports a hit only after both edges have been captured. A cell whose comparator is still high produces no output word.
- R8: A rising edge that reaches a cell holding an unread hit is dropped. That cell's stored hit is unchanged, and `lost_cnt` increments by one per dropped edge, saturating at its maximum.
- R9: While `hit_valid`=1 and `hit_ready`=0, the output word and `hit_valid` hold unchanged.
- R10: In any cycle with `cfg_req`=1, no new hit word is loaded. If `hit_valid` was 0, it stays 0 in the next cycle.
- R11: After reset, `hit_valid`, `cfg_rvalid`, `lost_cnt` and every configuration word are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock for counter and column logic |
| rst_n | input | 1 | Active-low synchronous reset |
| comp_i | input | N_PIX | Comparator outputs, one per cell, asynchronous |
| cfg_req | input | 1 | Configuration access request |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | AW | Cell addressed by the access |
| cfg_wdata | input | CFG_W | Write data |
| cfg_rdata | output | CFG_W | Read data |
| cfg_rvalid | output | 1 | Read data valid, one cycle after a read request |
| hit_valid | output | 1 | Output hit word valid |
| hit_ready | input | 1 | Downstream accepts the hit word |
| hit_addr | output | AW | Address of the cell that produced the hit |
| hit_lead | output | TS_W | Leading timestamp, binary |
| hit_trail | output | TS_W | Trailing timestamp, binary |
| hit_tot | output | TS_W | Time over threshold, modulo difference |
| trim_o | output | N_PIX*TRIM_W | Threshold trim codes, five bits per cell |
| lost_cnt | output | LOST_W | Saturating count of dropped edges |

## Verification
The bench builds the column with eight cells, the full 12-bit timestamp and an 8-bit loss counter. Eight cells are enough to race three simultaneous hits through the priority scan. The full-width counter lets a pulse be placed across the 4095-to-0 wrap by aligning the start to the counter, using the synchronizer latency measured on an earlier hit. Holding `hit_ready` low while pulsing one cell three times lets the bench reach the lost-hit path and still drain the two stored hits afterwards. Holding a configuration read for many cycles shows the controller yielding to configuration traffic.

// File: rtl/pxcol_pkg.sv
package pxcol_pkg;
    localparam int TS_W   = 12;
    localparam int CFG_W  = 12;
    localparam int TRIM_W = 5;

    typedef enum logic {RD_IDLE, RD_SEND} rd_state_t;
    typedef enum logic [1:0] {CELL_ARMED, CELL_OPEN, CELL_FULL} cell_state_t;

    function automatic logic [TS_W-1:0] bin2gray(input logic [TS_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [TS_W-1:0] gray2bin(input logic [TS_W-1:0] g);
        logic [TS_W-1:0] b;
        b[TS_W-1] = g[TS_W-1];
        for (int i = TS_W-2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction
endpackage

// File: rtl/pxcol_tsgen.sv
module pxcol_tsgen
    import pxcol_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] ts_gray
);
    logic [TS_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            ts_gray <= '0;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
            ts_gray <= bin2gray(cnt_q);
        end
    end
endmodule

// File: rtl/pxcol_cell.sv
module pxcol_cell
    import pxcol_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              comp_i,
    input  logic [TS_W-1:0]   ts_gray_i,
    input  logic              ack_i,
    input  logic              cfg_we_i,
    input  logic [CFG_W-1:0]  cfg_wdata_i,
    output logic              rdy_o,
    output logic [TS_W-1:0]   lead_o,
    output logic [TS_W-1:0]   trail_o,
    output logic [CFG_W-1:0]  cfg_o,
    output logic [TRIM_W-1:0] trim_o,
    output logic              lost_o
);
    cell_state_t st_q, st_d;
    logic [2:0]  sync_q;
    logic        rise, fall, cap_lead, cap_trail;

    // two synchronizer flops plus one history flop for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], comp_i};
    end

    assign rise = sync_q[1] & ~sync_q[2];
    assign fall = ~sync_q[1] & sync_q[2];

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CELL_ARMED;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d      = st_q;
        cap_lead  = 1'b0;
        cap_trail = 1'b0;
        lost_o    = 1'b0;
        unique case (st_q)
            CELL_ARMED: if (rise) begin
                st_d     = CELL_OPEN;
                cap_lead = 1'b1;
            end
            CELL_OPEN: if (fall) begin
                st_d      = CELL_FULL;
                cap_trail = 1'b1;
            end
            CELL_FULL: begin
                lost_o = rise;
                if (ack_i) st_d = CELL_ARMED;
            end
            default: st_d = CELL_ARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lead_o  <= '0;
            trail_o <= '0;
            cfg_o   <= '0;
        end else begin
            if (cap_lead)  lead_o  <= ts_gray_i;
            if (cap_trail) trail_o <= ts_gray_i;
            if (cfg_we_i)  cfg_o   <= cfg_wdata_i;
        end
    end

    assign rdy_o  = (st_q == CELL_FULL);
    assign trim_o = cfg_o[TRIM_W-1:0];
endmodule

// File: rtl/pxcol_rdctl.sv
module pxcol_rdctl
    import pxcol_pkg::*;
#(
    parameter int N_PIX = 32,
    localparam int AW   = (N_PIX > 1) ? $clog2(N_PIX) : 1
)(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_PIX-1:0]           rdy_i,
    input  logic [N_PIX-1:0][TS_W-1:0] lead_g_i,
    input  logic [N_PIX-1:0][TS_W-1:0] trail_g_i,
    input  logic                       cfg_req_i,
    input  logic                       hit_ready_i,
    output logic [N_PIX-1:0]           ack_o,
    output logic                       hit_valid_o,
    output logic [AW-1:0]              hit_addr_o,
    output logic [TS_W-1:0]            hit_lead_o,
    output logic [TS_W-1:0]            hit_trail_o,
    output logic [TS_W-1:0]            hit_tot_o
);
    rd_state_t       st_q, st_d;
    logic [AW-1:0]   win;
    logic            any;
    logic            load;
    logic [TS_W-1:0] lead_b, trail_b;

    // fixed priority: lowest index wins, scanned from the top down
    always_comb begin
        win = '0;
        any = 1'b0;
        for (int i = N_PIX-1; i >= 0; i--) begin
            if (rdy_i[i]) begin
                win = AW'(i);
                any = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RD_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d  = st_q;
        load  = 1'b0;
        ack_o = '0;
        unique case (st_q)
            RD_IDLE: if (!cfg_req_i && any) begin
                load       = 1'b1;
                ack_o[win] = 1'b1;
                st_d       = RD_SEND;
            end
            RD_SEND: if (hit_ready_i) st_d = RD_IDLE;
            default: st_d = RD_IDLE;
        endcase
    end

    assign lead_b  = gray2bin(lead_g_i[win]);
    assign trail_b = gray2bin(trail_g_i[win]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_addr_o  <= '0;
            hit_lead_o  <= '0;
            hit_trail_o <= '0;
            hit_tot_o   <= '0;
        end else if (load) begin
            hit_addr_o  <= win;
            hit_lead_o  <= lead_b;
            hit_trail_o <= trail_b;
            hit_tot_o   <= trail_b - lead_b;
        end
    end

    assign hit_valid_o = (st_q == RD_SEND);
endmodule

// File: rtl/pxcol_top.sv
module pxcol_top
    import pxcol_pkg::*;
#(
    parameter int N_PIX  = 32,
    parameter int LOST_W = 8,
    localparam int AW    = (N_PIX > 1) ? $clog2(N_PIX) : 1
)(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_PIX-1:0]        comp_i,
    input  logic                    cfg_req,
    input  logic                    cfg_we,
    input  logic [AW-1:0]           cfg_addr,
    input  logic [CFG_W-1:0]        cfg_wdata,
    output logic [CFG_W-1:0]        cfg_rdata,
    output logic                    cfg_rvalid,
    output logic                    hit_valid,
    input  logic                    hit_ready,
    output logic [AW-1:0]           hit_addr,
    output logic [TS_W-1:0]         hit_lead,
    output logic [TS_W-1:0]         hit_trail,
    output logic [TS_W-1:0]         hit_tot,
    output logic [N_PIX*TRIM_W-1:0] trim_o,
    output logic [LOST_W-1:0]       lost_cnt
);
    logic [TS_W-1:0]             ts_gray;
    logic [N_PIX-1:0]            rdy, ack, lost, cfg_we_vec;
    logic [N_PIX-1:0][TS_W-1:0]  lead_g, trail_g;
    logic [N_PIX-1:0][CFG_W-1:0] cfg_arr;
    logic [LOST_W:0]             lost_next;
    logic [AW:0]                 lost_sum;

    pxcol_tsgen u_ts (.clk(clk), .rst_n(rst_n), .ts_gray(ts_gray));

    for (genvar g = 0; g < N_PIX; g++) begin : g_cell
        assign cfg_we_vec[g] = cfg_req && cfg_we && (int'(cfg_addr) == g);
        pxcol_cell u_cell (
            .clk(clk), .rst_n(rst_n), .comp_i(comp_i[g]), .ts_gray_i(ts_gray),
            .ack_i(ack[g]), .cfg_we_i(cfg_we_vec[g]), .cfg_wdata_i(cfg_wdata),
            .rdy_o(rdy[g]), .lead_o(lead_g[g]), .trail_o(trail_g[g]),
            .cfg_o(cfg_arr[g]), .trim_o(trim_o[g*TRIM_W +: TRIM_W]), .lost_o(lost[g])
        );
    end

    pxcol_rdctl #(.N_PIX(N_PIX)) u_rd (
        .clk(clk), .rst_n(rst_n), .rdy_i(rdy), .lead_g_i(lead_g), .trail_g_i(trail_g),
        .cfg_req_i(cfg_req), .hit_ready_i(hit_ready), .ack_o(ack),
        .hit_valid_o(hit_valid), .hit_addr_o(hit_addr), .hit_lead_o(hit_lead),
        .hit_trail_o(hit_trail), .hit_tot_o(hit_tot)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_rdata  <= '0;
            cfg_rvalid <= 1'b0;
        end else begin
            cfg_rvalid <= cfg_req && !cfg_we;
            if (cfg_req && !cfg_we)
                cfg_rdata <= (int'(cfg_addr) < N_PIX) ? cfg_arr[cfg_addr] : '0;
        end
    end

    always_comb begin
        lost_sum = '0;
        for (int i = 0; i < N_PIX; i++) lost_sum = lost_sum + (AW+1)'(lost[i]);
        lost_next = {1'b0, lost_cnt} + (LOST_W+1)'(lost_sum);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                lost_cnt <= '0;
        else if (lost_next[LOST_W]) lost_cnt <= '1;
        else                       lost_cnt <= lost_next[LOST_W-1:0];
    end
endmodule

// File: rtl/pxcol_chk.sv
module pxcol_chk
    import pxcol_pkg::*;
#(
    parameter int N_PIX  = 32,
    parameter int LOST_W = 8,
    localparam int AW    = (N_PIX > 1) ? $clog2(N_PIX) : 1
)(
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_req,
    input logic              cfg_we,
    input logic              cfg_rvalid,
    input logic              hit_valid,
    input logic              hit_ready,
    input logic [AW-1:0]     hit_addr,
    input logic [TS_W-1:0]   hit_lead,
    input logic [TS_W-1:0]   hit_trail,
    input logic [TS_W-1:0]   hit_tot,
    input logic [LOST_W-1:0] lost_cnt,
    input logic [TS_W-1:0]   ts_gray
);
    p_ts_onebit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ts_gray ^ $past(ts_gray)) <= 1);

    p_hit_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid && !hit_ready |=> hit_valid && $stable(hit_addr) && $stable(hit_lead)
                                    && $stable(hit_trail) && $stable(hit_tot));

    p_rvalid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req && !cfg_we |=> cfg_rvalid);

    p_no_rvalid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_req && !cfg_we) |=> !cfg_rvalid);

    p_lost_mono_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lost_cnt >= $past(lost_cnt));

    p_cfg_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req && !hit_valid |=> !hit_valid);
endmodule

bind pxcol_top pxcol_chk #(.N_PIX(N_PIX), .LOST_W(LOST_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_we(cfg_we),
    .cfg_rvalid(cfg_rvalid), .hit_valid(hit_valid), .hit_ready(hit_ready),
    .hit_addr(hit_addr), .hit_lead(hit_lead), .hit_trail(hit_trail),
    .hit_tot(hit_tot), .lost_cnt(lost_cnt), .ts_gray(ts_gray)
);

// File: tb/pxcol_top_tb.sv
module pxcol_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N    = 8;
    localparam int AW   = 3;
    localparam int TW   = 12;
    localparam int CW   = 12;
    localparam int LW   = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  comp_i = '0;
    logic          cfg_req = 1'b0, cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [CW-1:0] cfg_wdata = '0;
    logic [CW-1:0] cfg_rdata;
    logic          cfg_rvalid, hit_valid;
    logic          hit_ready = 1'b0;
    logic [AW-1:0] hit_addr;
    logic [TW-1:0] hit_lead, hit_trail, hit_tot;
    logic [N*5-1:0] trim_o;
    logic [LW-1:0] lost_cnt;

    int errors = 0, checks = 0;
    int cyc = 0;
    int rise_cyc = 0;
    int offset = 0;

    pxcol_top #(.N_PIX(N), .LOST_W(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .comp_i(comp_i), .cfg_req(cfg_req), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cfg_rvalid(cfg_rvalid), .hit_valid(hit_valid), .hit_ready(hit_ready),
        .hit_addr(hit_addr), .hit_lead(hit_lead), .hit_trail(hit_trail),
        .hit_tot(hit_tot), .trim_o(trim_o), .lost_cnt(lost_cnt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [N-1:0] mask, input int width);
        @(negedge clk);
        comp_i = comp_i | mask;
        rise_cyc = cyc;
        repeat (width) @(negedge clk);
        comp_i = comp_i & ~mask;
    endtask

    task automatic get_word(output int a, output int l, output int t, output int tot);
        int n = 0;
        @(negedge clk);
        while (!hit_valid && n < 200) begin @(negedge clk); n++; end
        chk(hit_valid, "R7 word expected", int'(hit_valid), 1);
        a = hit_addr; l = hit_lead; t = hit_trail; tot = hit_tot;
        hit_ready = 1'b1;
        @(negedge clk);
        hit_ready = 1'b0;
    endtask

    task automatic cfg_write(input int a, input int d);
        @(negedge clk);
        cfg_req = 1'b1; cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = CW'(d);
        @(negedge clk);
        cfg_req = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input int a, output int d);
        @(negedge clk);
        cfg_req = 1'b1; cfg_we = 1'b0; cfg_addr = AW'(a);
        @(negedge clk);
        cfg_req = 1'b0;
        chk(cfg_rvalid, "R4 rvalid next cycle", int'(cfg_rvalid), 1);
        d = cfg_rdata;
        @(negedge clk);
        chk(!cfg_rvalid, "R4 rvalid one cycle", int'(cfg_rvalid), 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!hit_valid, "R11 hit_valid", int'(hit_valid), 0);
        chk(!cfg_rvalid, "R11 cfg_rvalid", int'(cfg_rvalid), 0);
        chk(lost_cnt == 0, "R11 lost_cnt", int'(lost_cnt), 0);
        chk(trim_o == '0, "R11 trim", int'(trim_o), 0);
    endtask

    task automatic t_config();
        int d;
        cfg_write(3, 'hA5C);
        cfg_write(0, 'h3F1);
        cfg_read(3, d);
        chk(d == 'hA5C, "R4 readback cell 3", d, 'hA5C);
        cfg_read(0, d);
        chk(d == 'h3F1, "R4 readback cell 0", d, 'h3F1);
        chk(trim_o[3*5 +: 5] == 5'h1C, "R5 trim cell 3", int'(trim_o[3*5 +: 5]), 'h1C);
        chk(trim_o[0 +: 5] == 5'h11, "R5 trim cell 0", int'(trim_o[0 +: 5]), 'h11);
    endtask

    task automatic t_single();
        int a, l, t, tot;
        pulse(8'h20, 10);
        get_word(a, l, t, tot);
        chk(a == 5, "R3 addr", a, 5);
        chk(tot == 10, "R3 tot", tot, 10);
        chk(((t - l) & 'hFFF) == 10, "R1 binary trail-lead", (t - l) & 'hFFF, 10);
        offset = (l - rise_cyc) & 'hFFF;
    endtask

    task automatic t_lead_align();
        int a, l, t, tot;
        pulse(8'h01, 33);
        get_word(a, l, t, tot);
        chk(l == ((rise_cyc + offset) & 'hFFF), "R2 lead latency", l, (rise_cyc + offset) & 'hFFF);
        chk(tot == 33, "R3 tot 33", tot, 33);
    endtask

    task automatic t_priority();
        int a, l, t, tot;
        pulse(8'h54, 6);
        get_word(a, l, t, tot);
        chk(a == 2, "R6 first", a, 2);
        get_word(a, l, t, tot);
        chk(a == 4, "R6 second", a, 4);
        get_word(a, l, t, tot);
        chk(a == 6, "R6 third", a, 6);
        chk(tot == 6, "R3 tot shared pulse", tot, 6);
    endtask

    task automatic t_both_edges();
        int a, l, t, tot;
        bit seen = 0;
        @(negedge clk);
        comp_i[7] = 1'b1;
        repeat (20) begin @(negedge clk); if (hit_valid) seen = 1; end
        comp_i[7] = 1'b0;
        chk(!seen, "R7 no word while high", int'(seen), 0);
        get_word(a, l, t, tot);
        chk(a == 7 && tot == 20, "R7 word after fall", tot, 20);
    endtask

    task automatic t_lost_hold();
        int a, l, t, tot;
        logic [TW-1:0] s_l, s_t;
        pulse(8'h02, 4);  repeat (6) @(negedge clk);
        pulse(8'h02, 7);  repeat (6) @(negedge clk);
        pulse(8'h02, 9);  repeat (6) @(negedge clk);
        chk(lost_cnt == 1, "R8 lost count", int'(lost_cnt), 1);
        chk(hit_valid, "R9 valid while stalled", int'(hit_valid), 1);
        s_l = hit_lead; s_t = hit_trail;
        repeat (5) @(negedge clk);
        chk(hit_valid && hit_lead == s_l && hit_trail == s_t && hit_tot == 4,
            "R9 word held", int'(hit_tot), 4);
        get_word(a, l, t, tot);
        chk(tot == 4, "R8 first stored", tot, 4);
        get_word(a, l, t, tot);
        chk(a == 1 && tot == 7, "R8 second kept, third dropped", tot, 7);
        repeat (10) @(negedge clk);
        chk(!hit_valid, "R8 no third word", int'(hit_valid), 0);
    endtask

    task automatic t_cfg_block();
        int a, l, t, tot;
        bit seen = 0, rv = 1;
        @(negedge clk);
        cfg_req = 1'b1; cfg_we = 1'b0; cfg_addr = 3'd3;
        pulse(8'h04, 5);
        repeat (15) begin @(negedge clk); if (hit_valid) seen = 1; if (!cfg_rvalid) rv = 0; end
        chk(!seen, "R10 no load during cfg", int'(seen), 0);
        chk(rv && cfg_rdata == 'hA5C, "R4 held read data", int'(cfg_rdata), 'hA5C);
        cfg_req = 1'b0;
        get_word(a, l, t, tot);
        chk(a == 2 && tot == 5, "R10 hit after cfg", tot, 5);
    endtask

    task automatic t_wrap();
        int a, l, t, tot;
        @(negedge clk);
        while (((cyc + 1 + offset) & 'hFFF) != 4000) @(negedge clk);
        pulse(8'h08, 300);
        get_word(a, l, t, tot);
        chk(l == 4000, "R3 wrap lead", l, 4000);
        chk(t == 204, "R3 wrap trail", t, 204);
        chk(tot == 300, "R3 wrap tot", tot, 300);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_config();
        t_single();
        t_lead_align();
        t_priority();
        t_both_edges();
        t_lost_hold();
        t_cfg_block();
        t_wrap();
        repeat (5) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule